// File: doc/BRIEF.md
# Valid-Region Tile Elementwise Sequencer

This block runs one elementwise binary operation over a two-dimensional tile held in on-chip SRAM. Two source tiles are read and one destination tile is written. A tile occupies a physical buffer of `phys_rows` by `phys_cols` elements. Only a smaller sub-rectangle of `valid_rows` by `valid_cols`, anchored at element (0, 0), holds meaningful data. The block walks that sub-rectangle. For each position it issues a read address to each source port and a write address with the result to the destination port.

Each of the three tiles has its own base address and its own storage order, row-major or column-major. A source is always read at the same (row, column) index as the destination, and no masking is applied to source reads. After the valid pass, an optional fill pass writes zero to every destination element outside the valid rectangle. A configuration is latched when a start is accepted. A configuration that is out of range raises an error flag and issues no access at all.

The SRAM returns read data one cycle after the address. The result is registered together with its delayed destination address, so the block finishes one element per clock.

Top module: `tile_ew_seq`

## Requirements
- R1: After an accepted start with a legal configuration, exactly `valid_rows`×`valid_cols` source reads are issued. The matching destination writes come in order: the row index is the outer loop and the column index is the inner loop, each starting at 0.
- R2: For a row-major tile (layout bit 0), the address of element (i, j) is base + i×`phys_cols` + j.
- R3: For a column-major tile (layout bit 1), the address of element (i, j) is base + i + j×`phys_rows`. Each of the three tiles picks its layout independently.
- R4: The destination value is op(src0, src1) on 16-bit words, with the source elements taken at the same (i, j) as the destination. The `op_sel` codes are 0 add, 1 subtract (src0−src1), 2 bitwise AND and 3 bitwise XOR. Add and subtract wrap modulo 2^16.
- R5: With `pad_zero` = 1, the fill pass follows the valid pass and writes 0 to every element with i ≥ `valid_rows` or j ≥ `valid_cols`. The fill pass goes in row order and skips the valid elements, so it takes one write per cycle.
- R6: With `pad_zero` = 0, no element outside the valid rectangle is written.
- R7: A start with `valid_rows` or `valid_cols` equal to 0, or larger than the physical size, sets `cfg_err` in the next cycle. Such a start issues no read, no write and no done pulse. `cfg_err` is cleared by the next accepted legal start.
- R8: Each destination write leaves the block two cycles after its source read. One element is issued every cycle, so `done` arrives N+3 cycles after the start edge, where N is the total number of writes.
- R9: `done` is high for exactly one cycle, in the cycle after the last write. `busy` is low in that cycle.
- R10: A start while `busy` is high is ignored. Configuration inputs that change during a run have no effect on that run.
- R11: While reset is held and right after it, `busy`, `done`, `cfg_err`, `rd_en` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Start request, accepted only when idle |
| op_sel | input | 2 | Operation code: 0 add, 1 sub, 2 and, 3 xor |
| pad_zero | input | 1 | 1 = zero-fill the area outside the valid region |
| phys_rows | input | DIM_W | Physical rows of all three tiles |
| phys_cols | input | DIM_W | Physical columns of all three tiles |
| valid_rows | input | DIM_W | Valid rows of the destination |
| valid_cols | input | DIM_W | Valid columns of the destination |
| src0_colmaj | input | 1 | Layout of source 0 (1 = column-major) |
| src1_colmaj | input | 1 | Layout of source 1 (1 = column-major) |
| dst_colmaj | input | 1 | Layout of the destination (1 = column-major) |
| src0_base | input | ADDR_W | Base address of source 0 |
| src1_base | input | ADDR_W | Base address of source 1 |
| dst_base | input | ADDR_W | Base address of the destination |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after the last write |
| cfg_err | output | 1 | Last accepted start had an illegal configuration |
| rd_en | output | 1 | Source read strobe (both ports) |
| rd_addr0 | output | ADDR_W | Source 0 read address |
| rd_addr1 | output | ADDR_W | Source 1 read address |
| rd_data0 | input | DATA_W | Source 0 read data, one cycle after the address |
| rd_data1 | input | DATA_W | Source 1 read data, one cycle after the address |
| wr_en | output | 1 | Destination write strobe |
| wr_addr | output | ADDR_W | Destination write address |
| wr_data | output | DATA_W | Destination write data |

## Verification
Two functions share a cycle. When the valid pass ends, the first fill-pass issue happens in the same cycle that the last valid-region results are still being computed and written. Also, a start pulse can arrive in the same cycle that the sequencer is busy. The bench provokes the first case with partial regions and zero fill on, with the gap in the columns and with the gap only in the rows. A scoreboard then judges the exact write order, the addresses, the data and the N+3 cycle count, so a lost, doubled or reordered write across the join is caught. The second case is provoked by pulsing start with a different configuration during a run. It is judged by an unchanged write sequence and by a single done pulse.

// File: rtl/tile_ew_pkg.sv
package tile_ew_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } ew_op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_VALID = 2'd1,
    PH_PAD   = 2'd2,
    PH_DRAIN = 2'd3
  } phase_e;
endpackage

// File: rtl/tile_addr_gen.sv
module tile_addr_gen #(
  parameter int DIM_W  = 5,
  parameter int ADDR_W = 12
) (
  input  logic              col_major,
  input  logic [ADDR_W-1:0] base,
  input  logic [DIM_W-1:0]  rows,
  input  logic [DIM_W-1:0]  cols,
  input  logic [DIM_W-1:0]  row_i,
  input  logic [DIM_W-1:0]  col_j,
  output logic [ADDR_W-1:0] addr
);
  localparam int PROD_W = 2 * DIM_W;

  logic [PROD_W-1:0] offset;

  // element offset chosen by the storage order of this tile
  always_comb begin
    if (col_major)
      offset = PROD_W'(row_i) + PROD_W'(col_j) * PROD_W'(rows);
    else
      offset = PROD_W'(row_i) * PROD_W'(cols) + PROD_W'(col_j);
    addr = base + ADDR_W'(offset);
  end
endmodule

// File: rtl/tile_ew_alu.sv
module tile_ew_alu import tile_ew_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    unique case (ew_op_e'(op))
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/tile_walker.sv
module tile_walker import tile_ew_pkg::*; #(
  parameter int DIM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             pad_en,
  input  logic [DIM_W-1:0] rows,
  input  logic [DIM_W-1:0] cols,
  input  logic [DIM_W-1:0] vrows,
  input  logic [DIM_W-1:0] vcols,
  input  logic             flight,
  input  logic             wr_fire,
  output logic             issue,
  output logic             issue_pad,
  output logic             busy,
  output logic             finish,
  output logic [DIM_W-1:0] row_i,
  output logic [DIM_W-1:0] col_j
);
  localparam logic [DIM_W-1:0] ONE = DIM_W'(1);

  phase_e           ph_q, ph_d;
  logic [DIM_W-1:0] i_d, j_d;
  logic             need_pad;

  assign need_pad = (vrows != rows) || (vcols != cols);
  assign busy     = (ph_q != PH_IDLE);

  always_comb begin
    ph_d      = ph_q;
    i_d       = row_i;
    j_d       = col_j;
    issue     = 1'b0;
    issue_pad = 1'b0;
    finish    = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (launch) begin
          ph_d = PH_VALID;
          i_d  = '0;
          j_d  = '0;
        end
      end
      PH_VALID: begin
        issue = 1'b1;
        if (col_j == vcols - ONE) begin
          j_d = '0;
          if (row_i == vrows - ONE) begin
            if (pad_en && need_pad) begin
              ph_d = PH_PAD;
              // first out-of-region element in row order
              if (vcols != cols) begin
                i_d = '0;
                j_d = vcols;
              end else begin
                i_d = vrows;
                j_d = '0;
              end
            end else begin
              ph_d = PH_DRAIN;
            end
          end else begin
            i_d = row_i + ONE;
          end
        end else begin
          j_d = col_j + ONE;
        end
      end
      PH_PAD: begin
        issue     = 1'b1;
        issue_pad = 1'b1;
        if (col_j == cols - ONE) begin
          if (row_i == rows - ONE) begin
            ph_d = PH_DRAIN;
          end else begin
            i_d = row_i + ONE;
            // rows still inside the valid band restart past the valid columns
            j_d = ((row_i + ONE) < vrows) ? vcols : '0;
          end
        end else begin
          j_d = col_j + ONE;
        end
      end
      PH_DRAIN: begin
        if (!flight && wr_fire) begin
          ph_d   = PH_IDLE;
          finish = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      row_i <= '0;
      col_j <= '0;
    end else begin
      ph_q  <= ph_d;
      row_i <= i_d;
      col_j <= j_d;
    end
  end
endmodule

// File: rtl/tile_ew_seq.sv
module tile_ew_seq import tile_ew_pkg::*; #(
  parameter int DIM_W  = 5,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op_sel,
  input  logic              pad_zero,
  input  logic [DIM_W-1:0]  phys_rows,
  input  logic [DIM_W-1:0]  phys_cols,
  input  logic [DIM_W-1:0]  valid_rows,
  input  logic [DIM_W-1:0]  valid_cols,
  input  logic              src0_colmaj,
  input  logic              src1_colmaj,
  input  logic              dst_colmaj,
  input  logic [ADDR_W-1:0] src0_base,
  input  logic [ADDR_W-1:0] src1_base,
  input  logic [ADDR_W-1:0] dst_base,
  output logic              busy,
  output logic              done,
  output logic              cfg_err,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr0,
  output logic [ADDR_W-1:0] rd_addr1,
  input  logic [DATA_W-1:0] rd_data0,
  input  logic [DATA_W-1:0] rd_data1,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int NPORT = 3;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  // configuration latched at an accepted start
  logic              accept, cfg_ok, launch;
  logic [1:0]        op_q, op_d;
  logic              pad_q, pad_d;
  logic [DIM_W-1:0]  rows_q, rows_d, cols_q, cols_d, vr_q, vr_d, vc_q, vc_d;
  logic [NPORT-1:0]  cm_q, cm_d;
  logic [ADDR_W-1:0] base_q [NPORT];
  logic [ADDR_W-1:0] base_d [NPORT];
  logic              err_d;

  assign accept = start && !busy;
  assign cfg_ok = (valid_rows != '0) && (valid_cols != '0) &&
                  (valid_rows <= phys_rows) && (valid_cols <= phys_cols);
  assign launch = accept && cfg_ok;

  always_comb begin
    op_d      = op_q;
    pad_d     = pad_q;
    rows_d    = rows_q;
    cols_d    = cols_q;
    vr_d      = vr_q;
    vc_d      = vc_q;
    cm_d      = cm_q;
    base_d[0] = base_q[0];
    base_d[1] = base_q[1];
    base_d[2] = base_q[2];
    err_d     = cfg_err;
    if (accept) err_d = !cfg_ok;
    if (launch) begin
      op_d      = op_sel;
      pad_d     = pad_zero;
      rows_d    = phys_rows;
      cols_d    = phys_cols;
      vr_d      = valid_rows;
      vc_d      = valid_cols;
      cm_d      = {dst_colmaj, src1_colmaj, src0_colmaj};
      base_d[0] = src0_base;
      base_d[1] = src1_base;
      base_d[2] = dst_base;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      op_q    <= '0;
      pad_q   <= 1'b0;
      rows_q  <= '0;
      cols_q  <= '0;
      vr_q    <= '0;
      vc_q    <= '0;
      cm_q    <= '0;
      cfg_err <= 1'b0;
      for (int k = 0; k < NPORT; k++) base_q[k] <= '0;
    end else begin
      op_q    <= op_d;
      pad_q   <= pad_d;
      rows_q  <= rows_d;
      cols_q  <= cols_d;
      vr_q    <= vr_d;
      vc_q    <= vc_d;
      cm_q    <= cm_d;
      cfg_err <= err_d;
      for (int k = 0; k < NPORT; k++) base_q[k] <= base_d[k];
    end
  end

  // walker
  logic             issue, issue_pad, finish;
  logic [DIM_W-1:0] row_i, col_j;
  logic             s1_v, s1_pad;

  tile_walker #(.DIM_W(DIM_W)) u_walk (
    .clk      (clk),
    .rst_n    (rst_sync),
    .launch   (launch),
    .pad_en   (pad_q),
    .rows     (rows_q),
    .cols     (cols_q),
    .vrows    (vr_q),
    .vcols    (vc_q),
    .flight   (s1_v),
    .wr_fire  (wr_en),
    .issue    (issue),
    .issue_pad(issue_pad),
    .busy     (busy),
    .finish   (finish),
    .row_i    (row_i),
    .col_j    (col_j)
  );

  // one address generator per tile port: 0 src0, 1 src1, 2 dst
  logic [ADDR_W-1:0] port_addr [NPORT];
  for (genvar p = 0; p < NPORT; p++) begin : g_agen
    tile_addr_gen #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_agen (
      .col_major(cm_q[p]),
      .base     (base_q[p]),
      .rows     (rows_q),
      .cols     (cols_q),
      .row_i    (row_i),
      .col_j    (col_j),
      .addr     (port_addr[p])
    );
  end

  assign rd_en    = issue && !issue_pad;
  assign rd_addr0 = port_addr[0];
  assign rd_addr1 = port_addr[1];

  // stage 1: read in flight, stage 2: registered write
  logic [ADDR_W-1:0] s1_addr, s1_addr_d;
  logic [DATA_W-1:0] alu_y, wdata_d;
  logic [ADDR_W-1:0] waddr_d;

  tile_ew_alu #(.DATA_W(DATA_W)) u_alu (
    .op(op_q),
    .a (rd_data0),
    .b (rd_data1),
    .y (alu_y)
  );

  always_comb begin
    s1_addr_d = issue ? port_addr[2] : s1_addr;
    waddr_d   = s1_v ? s1_addr : wr_addr;
    wdata_d   = wr_data;
    if (s1_v) wdata_d = s1_pad ? '0 : alu_y;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      s1_v    <= 1'b0;
      s1_pad  <= 1'b0;
      s1_addr <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      done    <= 1'b0;
    end else begin
      s1_v    <= issue;
      s1_pad  <= issue_pad;
      s1_addr <= s1_addr_d;
      wr_en   <= s1_v;
      wr_addr <= waddr_d;
      wr_data <= wdata_d;
      done    <= finish;
    end
  end
endmodule

// File: rtl/tile_ew_seq_chk.sv
module tile_ew_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic cfg_err,
  input logic rd_en,
  input logic wr_en
);
  // R1
  rd_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);

  // R8
  rd_to_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> ##1 wr_en);

  // R8
  wr_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  // R9
  done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(wr_en)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!busy && !rd_en && !wr_en));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(cfg_err));
endmodule

bind tile_ew_seq tile_ew_seq_chk i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .cfg_err(cfg_err),
  .rd_en  (rd_en),
  .wr_en  (wr_en)
);

// File: tb/test_tile_ew_seq.sv
`timescale 1ns/1ps
module test_tile_ew_seq;
  localparam int DIM_W  = 5;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op_sel = '0;
  logic pad_zero = 1'b0;
  logic [DIM_W-1:0] phys_rows = '0, phys_cols = '0, valid_rows = '0, valid_cols = '0;
  logic src0_colmaj = 1'b0, src1_colmaj = 1'b0, dst_colmaj = 1'b0;
  logic [ADDR_W-1:0] src0_base = '0, src1_base = '0, dst_base = '0;
  logic busy, done, cfg_err, rd_en, wr_en;
  logic [ADDR_W-1:0] rd_addr0, rd_addr1, wr_addr;
  logic [DATA_W-1:0] rd_data0 = '0, rd_data1 = '0, wr_data;

  always #2.5 clk = ~clk;

  tile_ew_seq #(.DIM_W(DIM_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_tile_ew_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .pad_zero(pad_zero),
    .phys_rows(phys_rows), .phys_cols(phys_cols), .valid_rows(valid_rows), .valid_cols(valid_cols),
    .src0_colmaj(src0_colmaj), .src1_colmaj(src1_colmaj), .dst_colmaj(dst_colmaj),
    .src0_base(src0_base), .src1_base(src1_base), .dst_base(dst_base),
    .busy(busy), .done(done), .cfg_err(cfg_err), .rd_en(rd_en),
    .rd_addr0(rd_addr0), .rd_addr1(rd_addr1), .rd_data0(rd_data0), .rd_data1(rd_data1),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int checks = 0;
  int errors = 0;
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
  logic [1:0] rd_hist = '0;
  logic [ADDR_W-1:0] q_addr[$];
  logic [DATA_W-1:0] q_data[$];

  function automatic logic [DATA_W-1:0] srcv(input logic [ADDR_W-1:0] a, input bit which);
    logic [DATA_W-1:0] w;
    w = DATA_W'(a);
    return which ? ((w * 16'd113) ^ 16'h5a5a) : (w * 16'd37 + 16'h0101);
  endfunction

  function automatic int eoff(input bit cm, input int i, input int j, input int r, input int c);
    return cm ? (i + j * r) : (i * c + j);
  endfunction

  function automatic logic [DATA_W-1:0] ref_op(input logic [1:0] op, input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    case (op)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return a & b;
      default: return a ^ b;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // SRAM model: one-cycle read latency
  always @(posedge clk) begin
    if (rd_en) begin
      rd_data0 <= srcv(rd_addr0, 1'b0);
      rd_data1 <= srcv(rd_addr1, 1'b1);
    end
  end

  // monitor: pops the scoreboard as writes appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_hist[1]) chk(wr_en == 1'b1, "R8 write two cycles after read", int'(wr_en), 1);
      rd_hist = {rd_hist[0], rd_en};
      if (rd_en) rd_cnt++;
      if (done) done_cnt++;
      if (wr_en) begin
        wr_cnt++;
        if (q_addr.size() == 0) begin
          chk(1'b0, "R6 unexpected write", int'(wr_addr), -1);
        end else begin
          logic [ADDR_W-1:0] ea;
          logic [DATA_W-1:0] ed;
          ea = q_addr.pop_front();
          ed = q_data.pop_front();
          chk(wr_addr == ea, "R1 R2 R3 write address", int'(wr_addr), int'(ea));
          chk(wr_data == ed, "R4 R5 write data", int'(wr_data), int'(ed));
        end
      end
    end
  end

  task automatic drive_cfg(input int r, input int c, input int vr, input int vc,
                           input bit m0, input bit m1, input bit md, input bit pz,
                           input logic [1:0] op, input int b0, input int b1, input int bd);
    phys_rows = DIM_W'(r);  phys_cols = DIM_W'(c);
    valid_rows = DIM_W'(vr); valid_cols = DIM_W'(vc);
    src0_colmaj = m0; src1_colmaj = m1; dst_colmaj = md; pad_zero = pz; op_sel = op;
    src0_base = ADDR_W'(b0); src1_base = ADDR_W'(b1); dst_base = ADDR_W'(bd);
  endtask

  task automatic run_case(input int r, input int c, input int vr, input int vc,
                          input bit m0, input bit m1, input bit md, input bit pz,
                          input logic [1:0] op, input int b0, input int b1, input int bd,
                          input bit disturb);
    int n, rd0, dn0, cyc;
    n = 0;
    for (int i = 0; i < vr; i++) begin
      for (int j = 0; j < vc; j++) begin
        q_addr.push_back(ADDR_W'(bd + eoff(md, i, j, r, c)));
        q_data.push_back(ref_op(op, srcv(ADDR_W'(b0 + eoff(m0, i, j, r, c)), 1'b0),
                                    srcv(ADDR_W'(b1 + eoff(m1, i, j, r, c)), 1'b1)));
        n++;
      end
    end
    if (pz) begin
      for (int i = 0; i < r; i++) begin
        for (int j = 0; j < c; j++) begin
          if (i >= vr || j >= vc) begin
            q_addr.push_back(ADDR_W'(bd + eoff(md, i, j, r, c)));
            q_data.push_back('0);
            n++;
          end
        end
      end
    end
    rd0 = rd_cnt;
    dn0 = done_cnt;
    @(negedge clk);
    drive_cfg(r, c, vr, vc, m0, m1, md, pz, op, b0, b1, bd);
    start = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (disturb && cyc == 2) begin
        // R10: new start and new configuration while busy
        chk(busy == 1'b1, "R10 busy during run", int'(busy), 1);
        drive_cfg(2, 2, 1, 1, ~m0, ~m1, ~md, ~pz, ~op, 7, 9, 11);
        start = 1'b1;
      end
    end while (!done && cyc < 5000);
    start = 1'b0;
    chk(cyc == n + 3, "R8 done cycle", cyc, n + 3);
    chk(busy == 1'b0, "R9 busy low at done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
    chk(q_addr.size() == 0, "R5 R6 missing writes", q_addr.size(), 0);
    chk(rd_cnt - rd0 == vr * vc, "R1 read count", rd_cnt - rd0, vr * vc);
    chk(done_cnt - dn0 == 1, "R9 done count", done_cnt - dn0, 1);
    chk(cfg_err == 1'b0, "R7 err clear after legal start", int'(cfg_err), 0);
    q_addr.delete();
    q_data.delete();
  endtask

  task automatic run_bad(input int r, input int c, input int vr, input int vc);
    int rd0, wr0, dn0;
    rd0 = rd_cnt; wr0 = wr_cnt; dn0 = done_cnt;
    @(negedge clk);
    drive_cfg(r, c, vr, vc, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 0, 40, 80);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cfg_err == 1'b1, "R7 err raised", int'(cfg_err), 1);
    chk(busy == 1'b0, "R7 not busy", int'(busy), 0);
    repeat (6) @(negedge clk);
    chk(rd_cnt == rd0, "R7 no reads", rd_cnt - rd0, 0);
    chk(wr_cnt == wr0, "R7 no writes", wr_cnt - wr0, 0);
    chk(done_cnt == dn0, "R7 no done", done_cnt - dn0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state while held
    chk({busy, done, cfg_err, rd_en, wr_en} == 5'b0, "R11 reset outputs",
        int'({busy, done, cfg_err, rd_en, wr_en}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, done, cfg_err, rd_en, wr_en} == 5'b0, "R11 after reset release",
        int'({busy, done, cfg_err, rd_en, wr_en}), 0);

    // full region, row-major everywhere, add: no fill needed
    run_case(4, 4, 4, 4, 0, 0, 0, 1, 2'd0, 0, 64, 128, 0);
    // partial region, mixed layouts, subtract, zero fill with column gap
    run_case(6, 5, 3, 2, 1, 0, 1, 1, 2'd1, 10, 100, 200, 0);
    // same region without fill, AND
    run_case(6, 5, 3, 2, 0, 1, 0, 0, 2'd2, 10, 100, 200, 0);
    // gap only in the rows, XOR, zero fill
    run_case(5, 4, 2, 4, 0, 1, 1, 1, 2'd3, 20, 300, 400, 0);
    // scalar tile
    run_case(1, 1, 1, 1, 1, 1, 1, 1, 2'd0, 5, 6, 7, 0);
    // tall tile, column-major destination, add wraps
    run_case(31, 3, 30, 2, 0, 1, 1, 1, 2'd0, 1000, 1500, 2000, 0);
    // R10: start and new config while busy
    run_case(4, 6, 3, 5, 0, 0, 0, 1, 2'd1, 50, 150, 250, 1);
    // R7: illegal configurations
    run_bad(4, 4, 0, 2);
    run_bad(4, 4, 2, 5);
    run_bad(3, 6, 4, 1);
    // legal start clears the error
    run_case(3, 3, 2, 2, 1, 0, 0, 0, 2'd3, 30, 60, 90, 0);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule